// File: doc/BRIEF.md
# Input Capture Pulse-Width Timer

This block measures how long an input pulse lasts, even when the pulse is much longer than one period of its timebase. A 16-bit up-counter advances on a count-clock enable strobe while counting is enabled. Four capture channels watch their own input pins. Each pin passes through a two-flop synchronizer and an edge detector. A 2-bit field per channel picks which edge opens a measurement and which edge closes it. At both edges the channel copies the timer value into its capture register.

Between the opening and closing edges each channel counts how many times the timer wrapped from its top value back to zero. At the closing edge it combines that count with the two captured values into a 24-bit extended width. The width is presented with a one-cycle valid pulse. A single sticky overflow bit cannot tell one wrap from several, so the per-channel wrap count is what makes widths of two or more timer periods come out right. The timer also keeps a global overflow flag that software clears, and it gives a one-cycle overflow interrupt pulse on every wrap. Capture registers are read through a registered read port.

Top module: `pulse_capture_timer`

## Requirements
- R1: While `count_en` is 1, `count` increases by one at each clock edge where `tick` is 1 and holds where `tick` is 0. From FFFFh it goes to 0000h. After reset, `count`, `ovf_flag`, `ovf_irq`, `rd_data` and all `width_valid` bits are 0.
- R2: While `count_en` is 0, `count` is forced to 0000h on the next edge, whatever `tick` does.
- R3: Every wrap from FFFFh to 0000h sets `ovf_flag` and raises `ovf_irq` for exactly one cycle. Both are visible in the same cycle in which `count` first shows 0000h.
- R4: `ovf_flag` stays set until a cycle with `ovf_clr` = 1 clears it on the next edge. If a wrap happens in the same cycle as the clear, the flag stays set.
- R5: Channel i takes its mode from `edge_sel[2i+1:2i]`. The codes are 0 = opens on rise and closes on fall, 1 = opens on fall and closes on rise, 2 = rise to rise, 3 = fall to fall. An input change applied before clock edge k is acted on at edge k+2.
- R6: At both the opening and the closing edge, the channel's capture register loads the value that `count` takes at that same clock edge. `rd_data` shows the capture register chosen by `rd_sel` one cycle after `rd_sel` is applied.
- R7: At the closing edge, `width_out[24i+23:24i]` is loaded with N×10000h + D1 − D0, kept to 24 bits. N is the number of wraps since the opening edge, and D0 and D1 are the two captured values. `width_valid[i]` is 1 for that one cycle only.
- R8: If a wrap happens at the same clock edge as a capture, the captured value is 0000h and the wrap counts as happening before the capture. At an opening edge the wrap is therefore left out of N, and at a closing edge it is included in N.
- R9: The per-channel wrap count saturates at its maximum (255 for the default 8-bit width). A wrap beyond that sets `wrap_sat[i]` and leaves N at the maximum. `wrap_sat[i]` stays set until the channel's next opening edge clears it.
- R10: After a closing edge the channel ignores edges until the next opening edge. In the rise-to-rise and fall-to-fall modes, the edge after a closing edge opens a new measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_en | input | 1 | Counter run enable; 0 holds the counter at zero |
| tick | input | 1 | Count-clock enable strobe |
| ovf_clr | input | 1 | Software clear of the overflow flag |
| cap_in | input | 4 | Asynchronous capture inputs, one per channel |
| edge_sel | input | 8 | 2-bit edge mode per channel |
| rd_sel | input | 2 | Capture register read select |
| count | output | 16 | Current timer value |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | One-cycle pulse on each wrap |
| rd_data | output | 16 | Selected capture register, registered |
| width_out | output | 96 | 24-bit extended width per channel |
| width_valid | output | 4 | One-cycle pulse when a channel's width is updated |
| wrap_sat | output | 4 | Per-channel wrap count saturation flag |

## Verification
`count`, `ovf_flag` and `ovf_irq` respond at the first clock edge after the inputs that cause them. A capture, together with any width, valid pulse and saturation flag it produces, lands at the third clock edge after the input pin changes (two synchronizer stages, then the capture itself), and `rd_data` follows one edge after that. A behavioural model in the bench steps through these same edge counts and is compared with every output on each falling clock edge. The directed checks read direct outputs right after the third edge and read recorded widths one falling edge later. Widths are also checked against the number of clock cycles between the two pin changes while `tick` is held at 1, which covers the two-wrap pulse and the capture that coincides with a wrap.

// File: rtl/pct_pkg.sv
package pct_pkg;

  typedef enum logic [1:0] {
    EM_RISE_FALL = 2'd0,
    EM_FALL_RISE = 2'd1,
    EM_RISE_RISE = 2'd2,
    EM_FALL_FALL = 2'd3
  } edge_mode_e;

  function automatic logic opens_on_rise(edge_mode_e m);
    return (m == EM_RISE_FALL) || (m == EM_RISE_RISE);
  endfunction

  function automatic logic closes_on_rise(edge_mode_e m);
    return (m == EM_FALL_RISE) || (m == EM_RISE_RISE);
  endfunction

endpackage

// File: rtl/pct_counter.sv
module pct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_en,
  input  logic             tick,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap,
  output logic             ovf_flag,
  output logic             ovf_irq
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  always_comb begin
    wrap = count_en && tick && (count == TOP);
    if (!count_en)
      cnt_nxt = '0;
    else if (tick)
      cnt_nxt = count + 1'b1;
    else
      cnt_nxt = count;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      ovf_flag <= 1'b0;
      ovf_irq  <= 1'b0;
    end else begin
      count    <= cnt_nxt;
      ovf_irq  <= wrap;
      ovf_flag <= wrap | (ovf_flag & ~ovf_clr);
    end
  end

endmodule

// File: rtl/pct_sync_edge.sv
module pct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise,
  output logic fall
);

  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst)
      chain <= '0;
    else
      chain <= {chain[STAGES-1:0], din};
  end

  always_comb begin
    rise = chain[STAGES-1] & ~chain[STAGES];
    fall = ~chain[STAGES-1] & chain[STAGES];
  end

endmodule

// File: rtl/pct_channel.sv
module pct_channel
  import pct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int WRAP_W = 8,
  localparam int RES_W = CNT_W + WRAP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  edge_mode_e       mode,
  input  logic             rise,
  input  logic             fall,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] cap_val,
  output logic [RES_W-1:0] width,
  output logic             width_valid,
  output logic             wrap_sat
);

  localparam logic [WRAP_W-1:0] WRAP_MAX = {WRAP_W{1'b1}};

  logic              armed;
  logic [CNT_W-1:0]  d0;
  logic [WRAP_W-1:0] wraps;
  logic [WRAP_W-1:0] wraps_eff;
  logic              sat_hit;
  logic              open_ev;
  logic              close_ev;
  logic [RES_W-1:0]  width_nxt;

  always_comb begin
    open_ev   = !armed && (opens_on_rise(mode) ? rise : fall);
    close_ev  = armed && (closes_on_rise(mode) ? rise : fall);
    sat_hit   = wrap && (wraps == WRAP_MAX);
    wraps_eff = (wrap && !sat_hit) ? wraps + 1'b1 : wraps;
    width_nxt = {wraps_eff, {CNT_W{1'b0}}} + RES_W'(cnt_nxt) - RES_W'(d0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed       <= 1'b0;
      d0          <= '0;
      wraps       <= '0;
      cap_val     <= '0;
      width       <= '0;
      width_valid <= 1'b0;
      wrap_sat    <= 1'b0;
    end else begin
      width_valid <= 1'b0;
      if (open_ev) begin
        armed    <= 1'b1;
        d0       <= cnt_nxt;
        cap_val  <= cnt_nxt;
        wraps    <= '0;
        wrap_sat <= 1'b0;
      end else if (armed) begin
        wraps <= wraps_eff;
        if (sat_hit)
          wrap_sat <= 1'b1;
        if (close_ev) begin
          armed       <= 1'b0;
          cap_val     <= cnt_nxt;
          width       <= width_nxt;
          width_valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pulse_capture_timer.sv
module pulse_capture_timer
  import pct_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int WRAP_W = 8,
  localparam int RES_W = CNT_W + WRAP_W,
  localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 count_en,
  input  logic                 tick,
  input  logic                 ovf_clr,
  input  logic [NCH-1:0]       cap_in,
  input  logic [2*NCH-1:0]     edge_sel,
  input  logic [SEL_W-1:0]     rd_sel,
  output logic [CNT_W-1:0]     count,
  output logic                 ovf_flag,
  output logic                 ovf_irq,
  output logic [CNT_W-1:0]     rd_data,
  output logic [NCH*RES_W-1:0] width_out,
  output logic [NCH-1:0]       width_valid,
  output logic [NCH-1:0]       wrap_sat
);

  logic [CNT_W-1:0] cnt_nxt;
  logic             wrap;
  logic [CNT_W-1:0] cap_q [NCH];

  pct_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .count_en (count_en),
    .tick     (tick),
    .ovf_clr  (ovf_clr),
    .count    (count),
    .cnt_nxt  (cnt_nxt),
    .wrap     (wrap),
    .ovf_flag (ovf_flag),
    .ovf_irq  (ovf_irq)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic rise;
    logic fall;

    pct_sync_edge #(.STAGES(2)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (cap_in[i]),
      .rise (rise),
      .fall (fall)
    );

    pct_channel #(.CNT_W(CNT_W), .WRAP_W(WRAP_W)) u_chan (
      .clk         (clk),
      .rst         (rst),
      .mode        (edge_mode_e'(edge_sel[2*i +: 2])),
      .rise        (rise),
      .fall        (fall),
      .wrap        (wrap),
      .cnt_nxt     (cnt_nxt),
      .cap_val     (cap_q[i]),
      .width       (width_out[RES_W*i +: RES_W]),
      .width_valid (width_valid[i]),
      .wrap_sat    (wrap_sat[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else
      rd_data <= cap_q[rd_sel];
  end

endmodule

// File: rtl/pct_checker.sv
module pct_checker #(
  parameter int NCH   = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             count_en,
  input logic             tick,
  input logic             ovf_clr,
  input logic [CNT_W-1:0] count,
  input logic             ovf_flag,
  input logic             ovf_irq,
  input logic [NCH-1:0]   width_valid
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  a_r2_hold_zero: assert property (@(posedge clk) disable iff (rst)
    !count_en |=> (count == '0));

  a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (count_en && !tick) |=> $stable(count));

  a_r1_step_up: assert property (@(posedge clk) disable iff (rst)
    (count_en && tick && count != TOP) |=> (count == CNT_W'($past(count) + 1'b1)));

  a_r3_wrap_irq: assert property (@(posedge clk) disable iff (rst)
    (count_en && tick && count == TOP) |=> (ovf_irq && ovf_flag && count == '0));

  a_r3_irq_at_zero: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |-> (count == '0 && ovf_flag));

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  a_r4_flag_clear: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !(count_en && tick && count == TOP)) |=> !ovf_flag);

  for (genvar i = 0; i < NCH; i++) begin : g_v
    a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
      width_valid[i] |=> !width_valid[i]);
  end

endmodule

bind pulse_capture_timer pct_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_pct_checker (
  .clk         (clk),
  .rst         (rst),
  .count_en    (count_en),
  .tick        (tick),
  .ovf_clr     (ovf_clr),
  .count       (count),
  .ovf_flag    (ovf_flag),
  .ovf_irq     (ovf_irq),
  .width_valid (width_valid)
);

// File: tb/tb_pulse_capture_timer.sv
module tb_pulse_capture_timer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 180000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        count_en = 1'b0;
  logic        tick = 1'b0;
  logic        ovf_clr = 1'b0;
  logic [3:0]  cap_in = '0;
  logic [7:0]  edge_sel = '0;
  logic [1:0]  rd_sel = '0;
  logic [15:0] count;
  logic        ovf_flag;
  logic        ovf_irq;
  logic [15:0] rd_data;
  logic [95:0] width_out;
  logic [3:0]  width_valid;
  logic [3:0]  wrap_sat;

  // small instance for the saturation case
  logic [1:0]  s_cap = '0;
  logic [3:0]  s_count;
  logic        s_flag, s_irq;
  logic [3:0]  s_rd;
  logic [13:0] s_width;
  logic [1:0]  s_valid, s_sat;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_capture_timer dut (
    .clk(clk), .rst(rst), .count_en(count_en), .tick(tick), .ovf_clr(ovf_clr),
    .cap_in(cap_in), .edge_sel(edge_sel), .rd_sel(rd_sel), .count(count),
    .ovf_flag(ovf_flag), .ovf_irq(ovf_irq), .rd_data(rd_data),
    .width_out(width_out), .width_valid(width_valid), .wrap_sat(wrap_sat)
  );

  pulse_capture_timer #(.NCH(2), .CNT_W(4), .WRAP_W(3)) dut_s (
    .clk(clk), .rst(rst), .count_en(1'b1), .tick(1'b1), .ovf_clr(1'b0),
    .cap_in(s_cap), .edge_sel(4'b0000), .rd_sel(1'b0), .count(s_count),
    .ovf_flag(s_flag), .ovf_irq(s_irq), .rd_data(s_rd),
    .width_out(s_width), .width_valid(s_valid), .wrap_sat(s_sat)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int tc = 0;
  bit slow = 1'b0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference model state
  int m_cnt, m_rd;
  bit m_flag, m_irq;
  int m_arm[4], m_d0[4], m_wr[4], m_cap[4], m_w[4];
  bit m_v[4], m_sat[4];
  bit q1[4], q2[4], q3[4];

  always @(posedge clk) begin : model
    int nxt;
    bit wrp, rs, fl, orise, crise;
    int md;
    cyc++;
    if (cyc >= WATCHDOG) begin
      errors++;
      $display("FAIL R1 watchdog actual %0d expected below %0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst) begin
      m_cnt = 0; m_flag = 0; m_irq = 0; m_rd = 0;
      for (int c = 0; c < 4; c++) begin
        m_arm[c] = 0; m_d0[c] = 0; m_wr[c] = 0; m_cap[c] = 0; m_w[c] = 0;
        m_v[c] = 0; m_sat[c] = 0; q1[c] = 0; q2[c] = 0; q3[c] = 0;
      end
    end else begin
      wrp = count_en && tick && (m_cnt == 65535);
      nxt = !count_en ? 0 : (tick ? (m_cnt + 1) % 65536 : m_cnt);
      m_rd = m_cap[rd_sel];
      for (int c = 0; c < 4; c++) begin
        m_v[c] = 0;
        rs = q2[c] && !q3[c];
        fl = !q2[c] && q3[c];
        md = int'(edge_sel[2*c +: 2]);
        orise = (md == 0) || (md == 2);
        crise = (md == 1) || (md == 2);
        if (m_arm[c] == 0 && (orise ? rs : fl)) begin
          m_arm[c] = 1; m_d0[c] = nxt; m_cap[c] = nxt; m_wr[c] = 0; m_sat[c] = 0;
        end else if (m_arm[c] != 0) begin
          if (wrp) begin
            if (m_wr[c] == 255) m_sat[c] = 1;
            else m_wr[c] = m_wr[c] + 1;
          end
          if (crise ? rs : fl) begin
            m_arm[c] = 0; m_cap[c] = nxt;
            m_w[c] = (m_wr[c] * 65536 + nxt - m_d0[c]) & 32'hFFFFFF;
            m_v[c] = 1;
          end
        end
        q3[c] = q2[c]; q2[c] = q1[c]; q1[c] = cap_in[c];
      end
      m_irq = wrp;
      m_flag = wrp ? 1'b1 : (ovf_clr ? 1'b0 : m_flag);
      m_cnt = nxt;
    end
  end

  // per-cycle comparison and width recording
  int w_last[4], seen[4];
  int s_last, s_seen;
  initial begin
    for (int c = 0; c < 4; c++) begin w_last[c] = 0; seen[c] = 0; end
    s_last = 0; s_seen = 0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R1 count", int'(count), m_cnt);
      check("R4 ovf_flag", int'(ovf_flag), int'(m_flag));
      check("R3 ovf_irq", int'(ovf_irq), int'(m_irq));
      check("R6 rd_data", int'(rd_data), m_rd);
      for (int c = 0; c < 4; c++) begin
        check("R5 R10 width_valid", int'(width_valid[c]), int'(m_v[c]));
        check("R9 wrap_sat", int'(wrap_sat[c]), int'(m_sat[c]));
        if (width_valid[c]) begin
          check("R7 width_out", int'(width_out[24*c +: 24]), m_w[c]);
          w_last[c] = int'(width_out[24*c +: 24]);
          seen[c]++;
        end
      end
      if (s_valid[0]) begin
        s_last = int'(s_width[6:0]);
        s_seen++;
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      tick = slow ? (tc % 3 == 0) : 1'b1;
      tc++;
    end
  endtask

  task automatic wait_count(int v);
    while (int'(count) != v) step(1);
  endtask

  int t0, t1, t2, t3, t4, ts, c1, base[4];

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    check("R1 reset count", int'(count), 0);
    check("R1 reset flag", int'(ovf_flag), 0);
    check("R1 reset valid", int'(width_valid), 0);
    check("R1 reset rd_data", int'(rd_data), 0);

    // R2: disabled counter ignores tick
    step(5);
    check("R2 held at zero", int'(count), 0);

    // irregular tick, varied modes and read selects
    edge_sel = {2'd3, 2'd2, 2'd1, 2'd0};
    count_en = 1'b1;
    slow = 1'b1;
    for (int c = 0; c < 4; c++) base[c] = seen[c];
    for (int i = 0; i < 48; i++) begin
      cap_in[i % 4] = ~cap_in[i % 4];
      rd_sel = 2'(i % 4);
      step(7 + (i * 13) % 29);
    end
    step(5);
    check("R5 R10 ch0 rise-fall count", seen[0] - base[0], 6);
    check("R5 R10 ch1 fall-rise count", seen[1] - base[1], 5);
    check("R5 R10 ch2 rise-rise count", seen[2] - base[2], 3);
    check("R5 R10 ch3 fall-fall count", seen[3] - base[3], 3);

    // restart for long-pulse phase
    rst = 1'b1;
    cap_in = '0;
    slow = 1'b0;
    step(3);
    rst = 1'b0;
    edge_sel = {2'd0, 2'd1, 2'd2, 2'd0};
    step(2);
    c1 = int'(count);
    step(1);
    check("R1 increment", int'(count), c1 + 1);

    cap_in[0] = 1'b1; t0 = cyc;
    step(100);
    cap_in[1] = 1'b1; t1 = cyc;
    step(10);
    cap_in[1] = 1'b0;
    wait_count(16'hFFFD);
    cap_in[1] = 1'b1; cap_in[3] = 1'b1; t2 = cyc;
    step(3);
    check("R3 flag after wrap", int'(ovf_flag), 1);
    rd_sel = 2'd3;
    step(1);
    check("R8 R6 capture at wrap reads zero", int'(rd_data), 0);
    check("R8 close on wrap width", w_last[1], t2 - t1);
    ovf_clr = 1'b1;
    step(1);
    ovf_clr = 1'b0;
    check("R4 flag cleared", int'(ovf_flag), 0);
    step(485);
    cap_in[3] = 1'b0; t3 = cyc;
    step(4);
    check("R8 open on wrap excludes wrap", w_last[3], t3 - t2);

    // R10: rise-rise channel opens again after a close
    cap_in[1] = 1'b0;
    step(20);
    cap_in[1] = 1'b1; t1 = cyc;
    step(30);
    cap_in[1] = 1'b0;
    step(30);
    cap_in[1] = 1'b1; t4 = cyc;
    step(4);
    check("R10 reopen width", w_last[1], t4 - t1);

    wait_count(16'hFFFF);
    ovf_clr = 1'b1;
    step(1);
    ovf_clr = 1'b0;
    check("R4 set wins over clear", int'(ovf_flag), 1);
    check("R3 irq pulse", int'(ovf_irq), 1);
    step(1);
    check("R3 irq one cycle", int'(ovf_irq), 0);

    while (cyc - t0 < 131172) step(1);
    cap_in[0] = 1'b0; t4 = cyc;
    step(4);
    check("R7 two-wrap width", w_last[0], t4 - t0);
    check("R7 width beyond two periods", int'(w_last[0] >= 32'h20000), 1);

    // R9 saturation on the reduced instance (4-bit timer, 3-bit wrap count)
    s_cap[0] = 1'b1;
    step(20);
    s_cap[0] = 1'b0;
    step(4);
    check("R9 short width", s_last, 20);
    check("R9 no saturation", int'(s_sat[0]), 0);
    s_cap[0] = 1'b1;
    step(144);
    s_cap[0] = 1'b0;
    step(3);
    check("R9 saturation flag", int'(s_sat[0]), 1);
    step(1);
    check("R9 saturated width", s_last, 7 * 16);
    s_cap[0] = 1'b1;
    step(3);
    check("R9 flag cleared at open", int'(s_sat[0]), 0);
    step(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule